// File: doc/BRIEF.md
# Per-Cluster Instruction Sequencer

This block is the sequencing unit of one cluster in a clustered VLIW machine that has no central program counter. Each cluster fetches from its own contiguous code region. The sequencer keeps a local program counter and drives it as the fetch address. It steps that counter by a fixed stride every cycle. Operations from the decode stage control it. Prepare-branch operations load cluster-local addresses into a small file of target registers. A compare operation sets a local predicate, and that predicate is also driven out to the other clusters. A branch operation names a target register and a predicate source. The source is either the local predicate or the broadcast line of another cluster, so every cluster transfers control on the same cycle.

The compiler can park a cluster across idle blocks with a sleeping branch. While parked, the cluster drops fetch enable, freezes its counter and ignores the operation inputs. It still watches the lock-step branch strobe and the predicate line chosen by the sleeping branch. When that line is true at a strobe, the cluster resumes at the address held in the target register that the sleeping branch named. A global stall freezes all state on any cycle it is high.

Top module: `cluster_seq`

## Requirements
- R1: During and after reset, fetch_addr_o equals START_ADDR, fetch_en_o is 1 and pred_bcast_o is 0. All target registers read as zero until they are written.
- R2: When the cluster is awake and not stalled, and no branch is taken, fetch_addr_o increases by PC_STEP on the next cycle.
- R3: A prepare-branch (pbr_en_i) writes pbr_addr_i into target register pbr_idx_i at the clock edge where it issues. A branch that issues on the same edge uses the previous contents.
- R4: A branch (br_en_i) evaluates the predicate chosen by br_psel_i. Value 0 selects the local predicate. Value k (1..3) selects remote_pred_i[k-1]. If the predicate is true, the next fetch_addr_o is target register br_idx_i. If it is false, the address advances as in R2.
- R5: A compare (cmp_en_i) loads cmp_val_i into the local predicate, which appears on pred_bcast_o one cycle later. A branch on the same edge uses the old predicate.
- R6: While stall_i is high, the fetch address, fetch enable, local predicate and target registers keep their values. Operations and wake events presented in that cycle have no effect.
- R7: A sleeping branch (br_sleep_i with br_en_i) whose predicate is true clears fetch_en_o on the next cycle and leaves fetch_addr_o unchanged.
- R8: While asleep, prepare-branch, compare and branch inputs are ignored.
- R9: While asleep and not stalled, a br_sync_i pulse with the sleeping branch's selected predicate true sets fetch_en_o to 1 and loads the target register named by the sleeping branch. A pulse with that predicate false keeps the cluster asleep.
- R10: A sleeping branch whose predicate is false behaves as a not-taken branch: the cluster stays awake and the address advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Global lock-step stall |
| pbr_en_i | input | 1 | Prepare-branch issues this cycle |
| pbr_idx_i | input | 2 | Target register written by the prepare-branch |
| pbr_addr_i | input | 32 | Cluster-local target address |
| cmp_en_i | input | 1 | Compare issues this cycle |
| cmp_val_i | input | 1 | Compare result |
| br_en_i | input | 1 | Branch issues this cycle |
| br_idx_i | input | 2 | Target register used by the branch |
| br_psel_i | input | 2 | Predicate source: 0 local, k remote line k-1 |
| br_sleep_i | input | 1 | Branch also puts the cluster to sleep |
| remote_pred_i | input | 3 | Predicates broadcast by the other clusters |
| br_sync_i | input | 1 | Lock-step branch strobe seen while asleep |
| fetch_addr_o | output | 32 | Local program counter / fetch address |
| fetch_en_o | output | 1 | Fetch enable (low while asleep) |
| pred_bcast_o | output | 1 | Local predicate broadcast to other clusters |

## Verification
Two kinds of collision can fall in the same cycle. First, a prepare-branch or compare can issue on the same edge as the branch that reads its target or predicate. Second, a stall can coincide with operations or with a wake strobe. The bench drives each collision in a single vector. It judges the result on the fetch address one cycle later: the branch must see the old target or predicate, and a stalled cycle must leave the address and enable unchanged. A follow-up branch or wake then shows at the ports that the stalled or sleeping write never landed.

// File: rtl/clseq_pkg.sv
package clseq_pkg;
  typedef enum logic {
    MODE_AWAKE  = 1'b0,
    MODE_ASLEEP = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/btr_file.sv
module btr_file #(
  parameter int ADDR_W  = 32,
  parameter int NUM_BTR = 4,
  localparam int IDX_W  = (NUM_BTR > 1) ? $clog2(NUM_BTR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] regs [NUM_BTR];

  for (genvar g = 0; g < NUM_BTR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))
        regs[g] <= wdata_i;
    end

    AST_BTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(we_i && widx_i == IDX_W'(g)) |=> $stable(regs[g])); // R6
  end

  assign rdata_o = regs[ridx_i];
endmodule

// File: rtl/pred_select.sv
module pred_select #(
  parameter int NUM_REMOTE = 3,
  localparam int SEL_W = $clog2(NUM_REMOTE + 1)
) (
  input  logic                  local_i,
  input  logic [NUM_REMOTE-1:0] remote_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  pred_o
);
  logic [NUM_REMOTE:0] lines;
  assign lines = {remote_i, local_i};

  always_comb begin
    pred_o = 1'b0;
    for (int k = 0; k <= NUM_REMOTE; k++)
      if (sel_i == SEL_W'(k)) pred_o = lines[k];
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import clseq_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] START_ADDR = 32'h0,
  parameter int          PC_STEP    = 1,
  parameter int          IDX_W      = 2,
  parameter int          SEL_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              br_en_i,
  input  logic              br_sleep_i,
  input  logic [IDX_W-1:0]  br_idx_i,
  input  logic [SEL_W-1:0]  br_psel_i,
  input  logic              pred_i,
  input  logic              sync_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              awake_o,
  output logic [IDX_W-1:0]  wake_idx_o,
  output logic [SEL_W-1:0]  wake_psel_o
);
  seq_mode_e mode;
  logic [ADDR_W-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= ADDR_W'(START_ADDR);
      mode        <= MODE_AWAKE;
      wake_idx_o  <= '0;
      wake_psel_o <= '0;
    end else if (!stall_i) begin
      if (mode == MODE_AWAKE) begin
        if (br_en_i && pred_i) begin
          if (br_sleep_i) begin
            mode        <= MODE_ASLEEP;
            wake_idx_o  <= br_idx_i;
            wake_psel_o <= br_psel_i;
          end else begin
            pc <= tgt_i;
          end
        end else begin
          pc <= pc + ADDR_W'(PC_STEP);
        end
      end else if (sync_i && pred_i) begin
        pc   <= tgt_i;
        mode <= MODE_AWAKE;
      end
    end
  end

  assign pc_o    = pc;
  assign awake_o = (mode == MODE_AWAKE);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> $stable(pc) && $stable(mode)); // R6
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (awake_o && !stall_i && !(br_en_i && pred_i)) |=> pc == $past(pc) + ADDR_W'(PC_STEP)); // R2
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (awake_o && !stall_i && br_en_i && br_sleep_i && pred_i) |=> !awake_o && $stable(pc)); // R7
  AST_ASLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!awake_o && !(!stall_i && sync_i && pred_i)) |=> !awake_o && $stable(pc)); // R8
  AST_WAKE: assert property (@(posedge clk) disable iff (rst)
    (!awake_o && !stall_i && sync_i && pred_i) |=> awake_o); // R9
endmodule

// File: rtl/cluster_seq.sv
module cluster_seq #(
  parameter int          ADDR_W     = 32,
  parameter int          NUM_BTR    = 4,
  parameter int          NUM_REMOTE = 3,
  parameter logic [31:0] START_ADDR = 32'h0,
  parameter int          PC_STEP    = 1,
  localparam int IDX_W = (NUM_BTR > 1) ? $clog2(NUM_BTR) : 1,
  localparam int SEL_W = $clog2(NUM_REMOTE + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stall_i,
  input  logic                  pbr_en_i,
  input  logic [IDX_W-1:0]      pbr_idx_i,
  input  logic [ADDR_W-1:0]     pbr_addr_i,
  input  logic                  cmp_en_i,
  input  logic                  cmp_val_i,
  input  logic                  br_en_i,
  input  logic [IDX_W-1:0]      br_idx_i,
  input  logic [SEL_W-1:0]      br_psel_i,
  input  logic                  br_sleep_i,
  input  logic [NUM_REMOTE-1:0] remote_pred_i,
  input  logic                  br_sync_i,
  output logic [ADDR_W-1:0]     fetch_addr_o,
  output logic                  fetch_en_o,
  output logic                  pred_bcast_o
);
  logic              awake;
  logic              local_pred;
  logic              pred;
  logic [IDX_W-1:0]  wake_idx;
  logic [SEL_W-1:0]  wake_psel;
  logic [IDX_W-1:0]  rd_idx;
  logic [SEL_W-1:0]  psel;
  logic [ADDR_W-1:0] tgt;
  logic              issue;

  assign issue  = awake && !stall_i;
  assign rd_idx = awake ? br_idx_i  : wake_idx;
  assign psel   = awake ? br_psel_i : wake_psel;

  always_ff @(posedge clk) begin
    if (rst)
      local_pred <= 1'b0;
    else if (issue && cmp_en_i)
      local_pred <= cmp_val_i;
  end

  btr_file #(.ADDR_W(ADDR_W), .NUM_BTR(NUM_BTR)) u_btr (
    .clk    (clk),
    .rst    (rst),
    .we_i   (issue && pbr_en_i),
    .widx_i (pbr_idx_i),
    .wdata_i(pbr_addr_i),
    .ridx_i (rd_idx),
    .rdata_o(tgt)
  );

  pred_select #(.NUM_REMOTE(NUM_REMOTE)) u_psel (
    .local_i (local_pred),
    .remote_i(remote_pred_i),
    .sel_i   (psel),
    .pred_o  (pred)
  );

  pc_unit #(
    .ADDR_W(ADDR_W), .START_ADDR(START_ADDR), .PC_STEP(PC_STEP),
    .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_pc (
    .clk        (clk),
    .rst        (rst),
    .stall_i    (stall_i),
    .br_en_i    (br_en_i),
    .br_sleep_i (br_sleep_i),
    .br_idx_i   (br_idx_i),
    .br_psel_i  (br_psel_i),
    .pred_i     (pred),
    .sync_i     (br_sync_i),
    .tgt_i      (tgt),
    .pc_o       (fetch_addr_o),
    .awake_o    (awake),
    .wake_idx_o (wake_idx),
    .wake_psel_o(wake_psel)
  );

  assign fetch_en_o   = awake;
  assign pred_bcast_o = local_pred;

  AST_PRED_STALL: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> $stable(pred_bcast_o)); // R6
  AST_PRED_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    !fetch_en_o |=> $stable(pred_bcast_o)); // R8
  AST_CMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (fetch_en_o && !stall_i && cmp_en_i) |=> pred_bcast_o == $past(cmp_val_i)); // R5
endmodule

// File: tb/tb_cluster_seq.sv
module tb_cluster_seq;
  typedef struct packed {
    logic        stall;
    logic        pbr;
    logic [1:0]  pidx;
    logic [31:0] paddr;
    logic        cmp;
    logic        cval;
    logic        br;
    logic [1:0]  bidx;
    logic [1:0]  psel;
    logic        slp;
    logic [2:0]  rem;
    logic        sync;
    logic [31:0] eaddr;
    logic        een;
    logic        epred;
    logic [3:0]  req;
  } vec_t;

  // Main table: START 0x100, stride 4
  localparam vec_t TABLE [10] = '{
    '{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,3'b000,1'b0,32'h104,1'b1,1'b0,4'd2}, // R2
    '{1'b0,1'b1,2'd1,32'h200,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,3'b000,1'b0,32'h108,1'b1,1'b0,4'd3}, // R3
    '{1'b0,1'b1,2'd1,32'h300,1'b0,1'b0,1'b1,2'd1,2'd1,1'b0,3'b001,1'b0,32'h200,1'b1,1'b0,4'd3}, // R3 old target
    '{1'b0,1'b0,2'd0,32'h0,  1'b1,1'b1,1'b1,2'd1,2'd0,1'b0,3'b000,1'b0,32'h204,1'b1,1'b1,4'd5}, // R5 old pred
    '{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b1,2'd1,2'd0,1'b0,3'b000,1'b0,32'h300,1'b1,1'b1,4'd4}, // R4 local
    '{1'b1,1'b1,2'd1,32'h500,1'b1,1'b0,1'b1,2'd1,2'd0,1'b0,3'b000,1'b0,32'h300,1'b1,1'b1,4'd6}, // R6 stall
    '{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b1,2'd1,2'd0,1'b0,3'b000,1'b0,32'h300,1'b1,1'b1,4'd6}, // R6 no write
    '{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b1,2'd1,2'd2,1'b0,3'b000,1'b0,32'h304,1'b1,1'b1,4'd4}, // R4 remote false
    '{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b1,2'd2,2'd3,1'b0,3'b100,1'b0,32'h0,  1'b1,1'b1,4'd1}, // R1 cleared reg, R4
    '{1'b0,1'b0,2'd0,32'h0,  1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,3'b000,1'b0,32'h4,  1'b1,1'b0,4'd5}  // R5
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        stall_i, pbr_en_i, cmp_en_i, cmp_val_i, br_en_i, br_sleep_i, br_sync_i;
  logic [1:0]  pbr_idx_i, br_idx_i, br_psel_i;
  logic [31:0] pbr_addr_i;
  logic [2:0]  remote_pred_i;
  logic [31:0] fetch_addr_o;
  logic        fetch_en_o, pred_bcast_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cluster_seq #(.START_ADDR(32'h100), .PC_STEP(4)) dut (
    .clk(clk), .rst(rst), .stall_i(stall_i),
    .pbr_en_i(pbr_en_i), .pbr_idx_i(pbr_idx_i), .pbr_addr_i(pbr_addr_i),
    .cmp_en_i(cmp_en_i), .cmp_val_i(cmp_val_i),
    .br_en_i(br_en_i), .br_idx_i(br_idx_i), .br_psel_i(br_psel_i), .br_sleep_i(br_sleep_i),
    .remote_pred_i(remote_pred_i), .br_sync_i(br_sync_i),
    .fetch_addr_o(fetch_addr_o), .fetch_en_o(fetch_en_o), .pred_bcast_o(pred_bcast_o)
  );

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    stall_i = v.stall; pbr_en_i = v.pbr; pbr_idx_i = v.pidx; pbr_addr_i = v.paddr;
    cmp_en_i = v.cmp; cmp_val_i = v.cval; br_en_i = v.br; br_idx_i = v.bidx;
    br_psel_i = v.psel; br_sleep_i = v.slp; remote_pred_i = v.rem; br_sync_i = v.sync;
    @(posedge clk);
    @(negedge clk);
    check(int'(v.req), "fetch_addr", fetch_addr_o, v.eaddr);
    check(int'(v.req), "fetch_en", 32'(fetch_en_o), 32'(v.een));
    check(int'(v.req), "pred_bcast", 32'(pred_bcast_o), 32'(v.epred));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    stall_i = 0; pbr_en_i = 0; pbr_idx_i = 0; pbr_addr_i = 0; cmp_en_i = 0; cmp_val_i = 0;
    br_en_i = 0; br_idx_i = 0; br_psel_i = 0; br_sleep_i = 0; remote_pred_i = 0; br_sync_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(1, "reset addr", fetch_addr_o, 32'h100);
    check(1, "reset en", 32'(fetch_en_o), 32'd1);
    check(1, "reset pred", 32'(pred_bcast_o), 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 10; i++) apply(TABLE[i]);

    // Sleep / wake directed sequence
    do_reset();
    apply('{1'b0,1'b1,2'd3,32'h800,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,3'b000,1'b0,32'h104,1'b1,1'b0,4'd3});
    // R7 sleeping branch taken: fetch off, address held
    apply('{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b1,2'd3,2'd2,1'b1,3'b010,1'b0,32'h104,1'b0,1'b0,4'd7});
    // R8 ops while asleep ignored
    apply('{1'b0,1'b1,2'd3,32'h900,1'b1,1'b1,1'b1,2'd0,2'd0,1'b0,3'b111,1'b0,32'h104,1'b0,1'b0,4'd8});
    // R9 strobe with predicate false: stay asleep
    apply('{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,3'b000,1'b1,32'h104,1'b0,1'b0,4'd9});
    // R6 wake strobe during stall has no effect
    apply('{1'b1,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,3'b010,1'b1,32'h104,1'b0,1'b0,4'd6});
    // R9 wake to target 3 (old value, R8)
    apply('{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,3'b010,1'b1,32'h800,1'b1,1'b0,4'd9});
    // R2 resume stepping
    apply('{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,3'b000,1'b0,32'h804,1'b1,1'b0,4'd2});
    // R10 sleeping branch not taken
    apply('{1'b0,1'b0,2'd0,32'h0,  1'b0,1'b0,1'b1,2'd3,2'd1,1'b1,3'b000,1'b0,32'h808,1'b1,1'b0,4'd10});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule